// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers that let a PCI-style function signal interrupts by writing a message to memory. Software reaches it through 16-bit and 32-bit little-endian accesses at byte offsets from the capability base. It stores a control word, a low and a high message address, a 16-bit message data value and a per-vector mask. Only the enable bit and the multiple-message-enable field of the control word are writable. The other control bits come from a capability parameter fixed when the block is built. Two of those bits, 64-bit addressing and per-vector masking, decide where the data, upper-address and mask registers sit.

The function raises an interrupt by pulsing a request with a vector number. If the block is enabled and the vector is in range, the request is recorded as pending. The lowest-numbered pending vector that is not masked is then sent as one message on a valid/acknowledge port. The message carries the 64-bit address and the message data, with the low data bits replaced by the vector number. The block also reports the enabled-vector count, the capability size in bytes and one-cycle pulses when the enable bit rises or falls. A query port shows the data and mask state of any one vector.

Top module: `msicap_block`

## Requirements
- R1: After a synchronous reset the control word holds the capability value with bit 0 and bits 6:4 cleared. Address, data, mask and pending bits are zero, and no message is valid.
- R2: Control word bit 0 (enable) and bits 6:4 (multiple-message enable) are the only writable control bits. Bits 3:1 (vector capability), bit 7 (64-bit capable), bit 8 (mask capable) and bits 15:9 keep the capability value. A 16-bit write at 0x2 loads from data bits 15:0. A 32-bit write at 0x0 loads from data bits 31:16.
- R3: The low address is at 0x4. With 64-bit addressing the upper address is at 0x8, the data at 0xC and the mask at 0x10. Without it, the data is at 0x8 and the mask at 0xC. A 32-bit read at 0x0 returns the control word in bits 31:16. A read at 0x2 returns it in bits 15:0. A read of any other offset returns zero.
- R4: Bits 1:0 of the low address always read as zero.
- R5: Writes to offsets that are not valid for the current layout and width are ignored. A 16-bit write reaches only the control word and the data register. The upper address stays zero when 64-bit addressing is not capable.
- R6: The data register is 16 bits wide. A 32-bit write to it keeps the low 16 bits.
- R7: The enabled-vector count is 2 to the power of the multiple-message-enable field, and it is 0 for field values 6 and 7. The capability size is 0xA bytes, plus 0x4 if 64-bit capable, plus 0xA if mask capable.
- R8: `en_rise` is high for exactly one cycle after the enable bit goes from 0 to 1. `en_fall` is high for exactly one cycle after it goes from 1 to 0.
- R9: A vector counts as masked only when mask capability is set and its mask bit is 1.
- R10: A request for vector n is accepted when the block is enabled and n is below the vector count. The pending bit for n is set at the request edge, and `msg_valid` rises one cycle later. The message then carries address {upper, low} and data whose low log2(count) bits are replaced by n. The message holds stable until `msg_ack`.
- R11: A request for a masked vector stays pending and sends nothing until the vector is unmasked. When several vectors are sendable, the lowest-numbered one goes first.
- R12: A request made while disabled, or for a vector at or above the count, changes no pending bit and sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| cfg_wr_off | input | 5 | Write byte offset |
| cfg_wr_data | input | 32 | Write data, little-endian, 16-bit writes use bits 15:0 |
| cfg_rd_off | input | 5 | Read byte offset |
| cfg_rd_data | output | 32 | Read data for cfg_rd_off (combinational) |
| msi_on | output | 1 | Enable bit |
| en_rise | output | 1 | One-cycle pulse when the block becomes enabled |
| en_fall | output | 1 | One-cycle pulse when the block becomes disabled |
| vec_count | output | 7 | Number of enabled vectors |
| cap_size | output | 8 | Capability size in bytes |
| vec_sel | input | VW | Vector selected for the query outputs |
| vec_addr | output | 64 | Message address used by every vector |
| vec_data | output | 16 | Message data for the selected vector |
| vec_masked | output | 1 | Selected vector is masked |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | VW | Vector number of the request |
| pend_bits | output | VEC_MAX | Pending vectors |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| msg_ack | input | 1 | Message write accepted |

## Verification
The assertions check, on every cycle, the properties that hold at all times. The fixed control bits never move, the low address stays aligned, and the upper address stays zero when 64-bit addressing is not capable. Each enable pulse lasts one cycle and never overlaps the other, a message holds stable until it is acknowledged, and a rejected request leaves the pending bits alone. Other behaviour shows only in the bench scenarios. These are the layout that moves with the capability bits, the data bits replaced by the vector number, a masked vector waiting and then draining lowest-first, and the vector count for the out-of-range field codes.

// File: rtl/msicap_pkg.sv
package msicap_pkg;

    localparam int unsigned OFF_W       = 5;
    localparam logic [15:0] CTL_WR_MASK = 16'h0071;
    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_MME_LSB = 4;
    localparam int unsigned CTL_A64     = 7;
    localparam int unsigned CTL_PVM     = 8;

    typedef struct packed {
        logic             hi_ok;
        logic [OFF_W-1:0] hi_off;
        logic [OFF_W-1:0] data_off;
        logic             mask_ok;
        logic [OFF_W-1:0] mask_off;
    } layout_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    function automatic layout_t layout_of(input logic a64, input logic pvm);
        layout_t l;
        l.hi_ok    = a64;
        l.hi_off   = 5'h08;
        l.data_off = a64 ? 5'h0C : 5'h08;
        l.mask_ok  = pvm;
        l.mask_off = a64 ? 5'h10 : 5'h0C;
        return l;
    endfunction

    function automatic logic [6:0] vec_count_of(input logic [2:0] mme);
        return (mme > 3'd5) ? 7'd0 : (7'd1 << mme);
    endfunction

    function automatic logic [7:0] cap_bytes_of(input logic a64, input logic pvm);
        logic [7:0] s;
        s = 8'h0A;
        if (a64) s = s + 8'h04;
        if (pvm) s = s + 8'h0A;
        return s;
    endfunction

    function automatic logic [15:0] ctl_merge(input logic [15:0] cur, input logic [15:0] v);
        return (cur & ~CTL_WR_MASK) | (v & CTL_WR_MASK);
    endfunction

    function automatic logic [15:0] data_for_vec(input logic [15:0] d, input logic [2:0] mme,
                                                 input logic [4:0] vec);
        logic [15:0] m;
        m = (mme > 3'd5) ? 16'h0000 : (16'(vec_count_of(mme)) - 16'd1);
        return (d & ~m) | (16'(vec) & m);
    endfunction

endpackage

// File: rtl/msicap_regs.sv
module msicap_regs
    import msicap_pkg::*;
#(
    parameter logic [15:0] CAP_CTL = 16'h018A,
    parameter int unsigned VEC_MAX = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_wide,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [31:0]        wr_data,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [31:0]        rd_data,
    output logic               ctl_en,
    output logic [2:0]         ctl_mme,
    output logic               cap_a64,
    output logic               cap_pvm,
    output logic [63:0]        addr64,
    output logic [15:0]        data16,
    output logic [VEC_MAX-1:0] mask_eff,
    output logic               en_rise,
    output logic               en_fall
);

    logic [15:0]        ctl_q;
    logic [31:0]        lo_q, hi_q;
    logic [15:0]        data_q;
    logic [VEC_MAX-1:0] mask_q;
    logic               en_prev_q;
    layout_t            lay;
    logic [31:0]        mask_rd;

    assign cap_a64 = CAP_CTL[CTL_A64];
    assign cap_pvm = CAP_CTL[CTL_PVM];
    assign lay     = layout_of(cap_a64, cap_pvm);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= CAP_CTL & ~CTL_WR_MASK;
            lo_q      <= '0;
            hi_q      <= '0;
            data_q    <= '0;
            mask_q    <= '0;
            en_prev_q <= 1'b0;
        end else begin
            en_prev_q <= ctl_q[CTL_EN];
            if (wr_en) begin
                if (!wr_wide) begin
                    if (wr_off == 5'h02)
                        ctl_q <= ctl_merge(ctl_q, wr_data[15:0]);
                    else if (wr_off == lay.data_off)
                        data_q <= wr_data[15:0];
                end else begin
                    if (wr_off == 5'h00)
                        ctl_q <= ctl_merge(ctl_q, wr_data[31:16]);
                    else if (wr_off == 5'h04)
                        lo_q <= {wr_data[31:2], 2'b00};
                    else if (wr_off == lay.data_off)
                        data_q <= wr_data[15:0];
                    else if (lay.hi_ok && wr_off == lay.hi_off)
                        hi_q <= wr_data;
                    else if (lay.mask_ok && wr_off == lay.mask_off)
                        mask_q <= wr_data[VEC_MAX-1:0];
                end
            end
        end
    end

    always_comb begin
        mask_rd = '0;
        mask_rd[VEC_MAX-1:0] = mask_q;
        rd_data = '0;
        if (rd_off == 5'h00)
            rd_data = {ctl_q, 16'h0000};
        else if (rd_off == 5'h02)
            rd_data = {16'h0000, ctl_q};
        else if (rd_off == 5'h04)
            rd_data = lo_q;
        else if (lay.hi_ok && rd_off == lay.hi_off)
            rd_data = hi_q;
        else if (rd_off == lay.data_off)
            rd_data = {16'h0000, data_q};
        else if (lay.mask_ok && rd_off == lay.mask_off)
            rd_data = mask_rd;
    end

    assign ctl_en   = ctl_q[CTL_EN];
    assign ctl_mme  = ctl_q[CTL_MME_LSB +: 3];
    assign addr64   = {hi_q, lo_q};
    assign data16   = data_q;
    assign mask_eff = cap_pvm ? mask_q : '0;
    assign en_rise  = ctl_q[CTL_EN] & ~en_prev_q;
    assign en_fall  = ~ctl_q[CTL_EN] & en_prev_q;

    AST_CTL_FIXED: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & ~CTL_WR_MASK) == (CAP_CTL & ~CTL_WR_MASK)); // R2
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        lo_q[1:0] == 2'b00); // R4
    AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cap_a64 |-> hi_q == 32'h0); // R5
    AST_RISE_ONE: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> !en_rise); // R8
    AST_FALL_ONE: assert property (@(posedge clk) disable iff (rst)
        en_fall |=> !en_fall); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(en_rise && en_fall)); // R8

endmodule

// File: rtl/msicap_dispatch.sv
module msicap_dispatch
    import msicap_pkg::*;
#(
    parameter int unsigned VEC_MAX = 32,
    localparam int unsigned VW     = (VEC_MAX > 1) ? $clog2(VEC_MAX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enabled,
    input  logic [2:0]         mme,
    input  logic [VEC_MAX-1:0] mask_eff,
    input  logic [63:0]        addr64,
    input  logic [15:0]        data16,
    input  logic               irq_req,
    input  logic [VW-1:0]      irq_vec,
    input  logic               msg_ack,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VEC_MAX-1:0] pend
);

    logic [VEC_MAX-1:0] pend_q, pend_n, ready;
    logic [VW-1:0]      cur_q, pick_idx;
    logic               pick_ok, valid_q, accept, done;
    msg_t               msg_q;
    logic [6:0]         vcount;

    assign vcount = vec_count_of(mme);
    assign accept = irq_req && enabled && (7'(irq_vec) < vcount);
    assign done   = valid_q && msg_ack;
    assign ready  = pend_q & ~mask_eff;

    always_comb begin
        pick_ok  = 1'b0;
        pick_idx = '0;
        for (int i = VEC_MAX - 1; i >= 0; i--) begin
            if (ready[i] && (7'(i) < vcount)) begin
                pick_ok  = 1'b1;
                pick_idx = VW'(i);
            end
        end
    end

    always_comb begin
        pend_n = pend_q;
        if (done)   pend_n[cur_q]   = 1'b0;
        if (accept) pend_n[irq_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            valid_q <= 1'b0;
            cur_q   <= '0;
            msg_q   <= '0;
        end else begin
            pend_q <= pend_n;
            if (done) begin
                valid_q <= 1'b0;
            end else if (!valid_q && enabled && pick_ok) begin
                valid_q    <= 1'b1;
                cur_q      <= pick_idx;
                msg_q.addr <= addr64;
                msg_q.data <= {16'h0000, data_for_vec(data16, mme, 5'(pick_idx))};
            end
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = msg_q.addr;
    assign msg_data  = msg_q.data;
    assign pend      = pend_q;

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !msg_ack) |=> (valid_q && $stable(msg_q))); // R10
    AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(enabled)); // R10
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !enabled && !done) |=> pend_q == $past(pend_q)); // R12

endmodule

// File: rtl/msicap_block.sv
module msicap_block
    import msicap_pkg::*;
#(
    parameter logic [15:0] CAP_CTL = 16'h018A,
    parameter int unsigned VEC_MAX = 32,
    localparam int unsigned VW     = (VEC_MAX > 1) ? $clog2(VEC_MAX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_wide,
    input  logic [4:0]         cfg_wr_off,
    input  logic [31:0]        cfg_wr_data,
    input  logic [4:0]         cfg_rd_off,
    output logic [31:0]        cfg_rd_data,
    output logic               msi_on,
    output logic               en_rise,
    output logic               en_fall,
    output logic [6:0]         vec_count,
    output logic [7:0]         cap_size,
    input  logic [VW-1:0]      vec_sel,
    output logic [63:0]        vec_addr,
    output logic [15:0]        vec_data,
    output logic               vec_masked,
    input  logic               irq_req,
    input  logic [VW-1:0]      irq_vec,
    output logic [VEC_MAX-1:0] pend_bits,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    input  logic               msg_ack
);

    logic               ctl_en, cap_a64, cap_pvm;
    logic [2:0]         ctl_mme;
    logic [63:0]        addr64;
    logic [15:0]        data16;
    logic [VEC_MAX-1:0] mask_eff;

    msicap_regs #(.CAP_CTL(CAP_CTL), .VEC_MAX(VEC_MAX)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_wide  (cfg_wr_wide),
        .wr_off   (cfg_wr_off),
        .wr_data  (cfg_wr_data),
        .rd_off   (cfg_rd_off),
        .rd_data  (cfg_rd_data),
        .ctl_en   (ctl_en),
        .ctl_mme  (ctl_mme),
        .cap_a64  (cap_a64),
        .cap_pvm  (cap_pvm),
        .addr64   (addr64),
        .data16   (data16),
        .mask_eff (mask_eff),
        .en_rise  (en_rise),
        .en_fall  (en_fall)
    );

    msicap_dispatch #(.VEC_MAX(VEC_MAX)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .enabled   (ctl_en),
        .mme       (ctl_mme),
        .mask_eff  (mask_eff),
        .addr64    (addr64),
        .data16    (data16),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .msg_ack   (msg_ack),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .pend      (pend_bits)
    );

    assign msi_on     = ctl_en;
    assign vec_count  = vec_count_of(ctl_mme);
    assign cap_size   = cap_bytes_of(cap_a64, cap_pvm);
    assign vec_addr   = addr64;
    assign vec_data   = data_for_vec(data16, ctl_mme, 5'(vec_sel));
    assign vec_masked = mask_eff[vec_sel];

endmodule

// File: tb/msicap_block_tb.sv
`timescale 1ns/1ps
module msicap_block_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, b_wr_en = 1'b0, wr_wide = 1'b0;
    logic [4:0]  wr_off = '0, rd_off = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, b_rd_data;
    logic        msi_on, en_rise, en_fall, b_on, b_rise, b_fall;
    logic [6:0]  vec_count, b_count;
    logic [7:0]  cap_size, b_size;
    logic [4:0]  vec_sel = '0, irq_vec = '0;
    logic [63:0] vec_addr, b_addr, msg_addr, b_maddr;
    logic [15:0] vec_data, b_vdata;
    logic        vec_masked, b_masked;
    logic        irq_req = 1'b0, msg_ack = 1'b0;
    logic [31:0] pend_bits, b_pend;
    logic        msg_valid, b_mvalid;
    logic [31:0] msg_data, b_mdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [15:0] m_ctl;
    logic [31:0] m_lo, m_hi, m_mask;
    logic [15:0] m_data;

    always #2 clk = ~clk;

    msicap_block #(.CAP_CTL(16'h018A), .VEC_MAX(32)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_wr_wide(wr_wide), .cfg_wr_off(wr_off),
        .cfg_wr_data(wr_data), .cfg_rd_off(rd_off), .cfg_rd_data(rd_data), .msi_on(msi_on),
        .en_rise(en_rise), .en_fall(en_fall), .vec_count(vec_count), .cap_size(cap_size),
        .vec_sel(vec_sel), .vec_addr(vec_addr), .vec_data(vec_data), .vec_masked(vec_masked),
        .irq_req(irq_req), .irq_vec(irq_vec), .pend_bits(pend_bits), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack));

    msicap_block #(.CAP_CTL(16'h000A), .VEC_MAX(32)) u_dut_b (
        .clk(clk), .rst(rst), .cfg_wr_en(b_wr_en), .cfg_wr_wide(wr_wide), .cfg_wr_off(wr_off),
        .cfg_wr_data(wr_data), .cfg_rd_off(rd_off), .cfg_rd_data(b_rd_data), .msi_on(b_on),
        .en_rise(b_rise), .en_fall(b_fall), .vec_count(b_count), .cap_size(b_size),
        .vec_sel(vec_sel), .vec_addr(b_addr), .vec_data(b_vdata), .vec_masked(b_masked),
        .irq_req(1'b0), .irq_vec(5'd0), .pend_bits(b_pend), .msg_valid(b_mvalid),
        .msg_addr(b_maddr), .msg_data(b_mdata), .msg_ack(1'b0));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input bit tgt_b, input bit wide, input logic [4:0] off, input logic [31:0] v);
        @(negedge clk);
        wr_wide = wide; wr_off = off; wr_data = v;
        if (tgt_b) b_wr_en = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; b_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] off, output logic [31:0] a, output logic [31:0] b);
        rd_off = off;
        #0.5;
        a = rd_data; b = b_rd_data;
    endtask

    task automatic irq(input logic [4:0] v);
        @(negedge clk);
        irq_req = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic wait_msg();
        for (int i = 0; i < 20; i++) begin
            if (msg_valid) break;
            step();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] merge(input logic [15:0] c, input logic [15:0] v);
        return (c & ~16'h0071) | (v & 16'h0071);
    endfunction

    function automatic logic [6:0] exp_count(input logic [15:0] c);
        return (c[6:4] > 3'd5) ? 7'd0 : (7'd1 << c[6:4]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] off);
        case (off)
            5'h00:   return {m_ctl, 16'h0};
            5'h02:   return {16'h0, m_ctl};
            5'h04:   return m_lo;
            5'h08:   return m_hi;
            5'h0C:   return {16'h0, m_data};
            5'h10:   return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(input bit wide, input logic [4:0] off, input logic [31:0] v);
        if (!wide) begin
            if (off == 5'h02) m_ctl = merge(m_ctl, v[15:0]);
            else if (off == 5'h0C) m_data = v[15:0];
        end else begin
            case (off)
                5'h00: m_ctl = merge(m_ctl, v[31:16]);
                5'h04: m_lo = {v[31:2], 2'b00};
                5'h08: m_hi = v;
                5'h0C: m_data = v[15:0];
                5'h10: m_mask = v;
                default: ;
            endcase
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        logic [4:0] offs [6];
        offs[0] = 5'h00; offs[1] = 5'h02; offs[2] = 5'h04;
        offs[3] = 5'h08; offs[4] = 5'h0C; offs[5] = 5'h10;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rd(5'h00, a, b);
        chk("R1 ctl", a, 64'h018A_0000);
        chk("R1 ctl b", b, 64'h000A_0000);
        rd(5'h04, a, b); chk("R1 lo", a, 0);
        rd(5'h0C, a, b); chk("R1 data", a, 0);
        rd(5'h10, a, b); chk("R1 mask", a, 0);
        chk("R1 valid", msg_valid, 0);
        chk("R1 pend", pend_bits, 0);
        chk("R1 on", msi_on, 0);
        // R7 size and count
        chk("R7 size a64 pvm", cap_size, 8'h18);
        chk("R7 size plain", b_size, 8'h0A);
        chk("R7 count mme0", vec_count, 1);

        // constrained random register traffic against the model (R2 R3 R4 R5 R6 R7)
        m_ctl = 16'h018A; m_lo = 0; m_hi = 0; m_data = 0; m_mask = 0;
        for (int it = 0; it < 300; it++) begin
            bit wide;
            logic [4:0] off;
            logic [31:0] v;
            int r;
            wide = 1'($urandom);
            r = int'($urandom % 8);
            off = (r < 6) ? offs[r] : 5'($urandom);
            v = $urandom;
            wr(1'b0, wide, off, v);
            model_wr(wide, off, v);
            for (int k = 0; k < 6; k++) begin
                rd(offs[k], a, b);
                chk("R3 random read", a, exp_rd(offs[k]));
            end
            chk("R7 random count", vec_count, exp_count(m_ctl));
        end

        do_reset();
        // R2 writable bits only, 16-bit at 0x2
        wr(1'b0, 1'b0, 5'h02, 32'h0000_FFFF);
        rd(5'h02, a, b); chk("R2 ctl16", a, 32'h0000_01FB);
        chk("R8 rise", en_rise, 1);
        step(); chk("R8 rise one cycle", en_rise, 0);
        // R2 32-bit at 0x0 uses upper half
        wr(1'b0, 1'b1, 5'h00, 32'h0000_FFFF);
        rd(5'h02, a, b); chk("R2 ctl32 upper half", a, 32'h0000_018A);
        chk("R8 fall", en_fall, 1);
        step(); chk("R8 fall one cycle", en_fall, 0);
        // R7 out-of-range codes
        wr(1'b0, 1'b0, 5'h02, 32'h0000_0060);
        chk("R7 mme6", vec_count, 0);
        wr(1'b0, 1'b0, 5'h02, 32'h0000_0070);
        chk("R7 mme7", vec_count, 0);
        wr(1'b0, 1'b0, 5'h02, 32'h0000_0050);
        chk("R7 mme5", vec_count, 32);

        // program message registers
        wr(1'b0, 1'b1, 5'h04, 32'h1234_5677);
        rd(5'h04, a, b); chk("R4 lo align", a, 32'h1234_5674);
        wr(1'b0, 1'b0, 5'h04, 32'h0000_FFFF);
        rd(5'h04, a, b); chk("R5 16b to lo ignored", a, 32'h1234_5674);
        wr(1'b0, 1'b1, 5'h08, 32'hAABB_0000);
        wr(1'b0, 1'b1, 5'h0C, 32'hDEAD_5A5F);
        rd(5'h0C, a, b); chk("R6 data low16", a, 32'h0000_5A5F);
        rd(5'h08, a, b); chk("R3 hi at 8", a, 32'hAABB_0000);
        wr(1'b0, 1'b0, 5'h02, 32'h0000_0031);
        chk("R7 mme3", vec_count, 8);
        vec_sel = 5'd3;
        #0.5;
        chk("R10 vec data", vec_data, 16'h5A5B);

        // R10 unmasked request
        irq(5'd5);
        chk("R10 pend at request", pend_bits, 32'h20);
        chk("R10 not yet valid", msg_valid, 0);
        step();
        chk("R10 valid", msg_valid, 1);
        chk("R10 addr", msg_addr, 64'hAABB_0000_1234_5674);
        chk("R10 data", msg_data, 32'h0000_5A5D);
        step();
        chk("R10 hold", msg_valid, 1);
        ack();
        chk("R10 done", msg_valid, 0);
        chk("R10 pend clear", pend_bits, 0);

        // R11 masked request waits
        wr(1'b0, 1'b1, 5'h10, 32'h0000_0004);
        vec_sel = 5'd2;
        #0.5;
        chk("R9 masked", vec_masked, 1);
        irq(5'd2);
        repeat (3) step();
        chk("R11 masked pending", pend_bits, 32'h4);
        chk("R11 masked silent", msg_valid, 0);
        wr(1'b0, 1'b1, 5'h10, 32'h0);
        wait_msg();
        chk("R11 sent after unmask", msg_valid, 1);
        chk("R11 data", msg_data, 32'h0000_5A5A);
        ack();

        // R11 lowest first
        wr(1'b0, 1'b1, 5'h10, 32'h0000_0003);
        irq(5'd1);
        irq(5'd0);
        step();
        chk("R11 both pending", pend_bits, 32'h3);
        wr(1'b0, 1'b1, 5'h10, 32'h0);
        wait_msg();
        chk("R11 first vec0", msg_data, 32'h0000_5A58);
        ack();
        wait_msg();
        chk("R11 second vec1", msg_data, 32'h0000_5A59);
        ack();
        chk("R11 drained", pend_bits, 0);

        // R12 out of range and disabled
        irq(5'd9);
        step();
        chk("R12 out of range pend", pend_bits, 0);
        chk("R12 out of range msg", msg_valid, 0);
        wr(1'b0, 1'b0, 5'h02, 32'h0000_0030);
        chk("R8 fall again", en_fall, 1);
        irq(5'd1);
        step();
        chk("R12 disabled pend", pend_bits, 0);
        chk("R12 disabled msg", msg_valid, 0);

        // second configuration: 32-bit layout, no masking (R3 R5 R9)
        wr(1'b1, 1'b1, 5'h08, 32'h1111_BEEF);
        rd(5'h08, a, b); chk("R3 b data at 8", b, 32'h0000_BEEF);
        wr(1'b1, 1'b1, 5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, a, b); chk("R5 b mask ignored", b, 0);
        chk("R5 b hi zero", b_addr[63:32], 0);
        rd(5'h10, a, b); chk("R3 b 0x10 reads zero", b, 0);
        chk("R9 b never masked", b_masked, 0);
        wr(1'b1, 1'b0, 5'h08, 32'h0000_0123);
        rd(5'h08, a, b); chk("R3 b data16 at 8", b, 32'h0000_0123);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule